// File: doc/BRIEF.md
# Bit-Serial ALU with Bit-Time Sequencer

This block performs 8-bit arithmetic and logic one bit per clock. A free-running bit counter divides time into packets of `WIDTH` slots and decodes the count into a one-hot strobe bus, one line per slot. At the start of every packet the block samples two parallel operands and a 4-bit opcode. It then streams the result out on a single wire, least significant bit first.

All arithmetic runs through one full adder. An XOR stage in front of each adder input can ones'-complement that operand. In slot 0 the adder's carry input is forced to a value chosen by the opcode. In every later slot it takes the carry stored by a single flip-flop during the slot before. At the end of each packet a carry flag and a zero flag are captured. A program-counter advance pulse is also produced in the final slot.

The surrounding machine presents the operands and opcode during slot 0, collects the serial result, and uses the flags on the next packet. The flags feed carry-chained arithmetic and conditional decisions.

Top module: `serial_alu`

## Requirements
- R1: `bit_strobe_o` is one-hot at all times. Bit k is high during slot k. The slots run 0,1,…,WIDTH-1 and then wrap to 0. Slot 0 is active during reset and remains active until the first clock edge after reset is released. In reset, `carry_o` is 0 and `zero_o` is 1.
- R2: `pc_adv_o` is high in slot WIDTH-1 and low in every other slot, so it pulses exactly once per packet.
- R3: During slot k, `sum_o` carries bit k of the packet's result, least significant bit first. The operands and the opcode are taken in slot 0. Changing `opa_i`, `opb_i` or `opcode_i` in any other slot has no effect on that packet's result or flags.
- R4: Opcode 0 gives A+B. Opcode 1 gives A−B, computed as A+~B+1. Opcode 10 gives B−A, computed as ~A+B+1. All three results are taken modulo 2^WIDTH.
- R5: Opcode 2 gives A+B+C. Opcode 3 gives A+~B+C. In both, C is the value of `carry_o` left by the previous packet.
- R6: Opcode 4 gives A AND B. Opcode 5 gives A OR B. Opcode 6 gives A XOR B. Opcode 7 gives ~A. After each of these four operations, `carry_o` is 0.
- R7: Opcode 8 gives A+1. Opcode 9 gives A−1, computed as A plus all ones. For both, operand B is ignored.
- R8: For the arithmetic opcodes, `carry_o` is the carry out of bit WIDTH-1. The flag updates at the clock edge that ends slot WIDTH-1 and then holds through the whole next packet.
- R9: `zero_o` is 1 exactly when every result bit of the last packet was 0. It updates at the same edge as `carry_o` and holds through the next packet in the same way.
- R10: Opcodes 11 to 15 behave as opcode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opa_i | input | WIDTH | Operand A, sampled in slot 0 |
| opb_i | input | WIDTH | Operand B, sampled in slot 0 |
| opcode_i | input | 4 | Operation select, sampled in slot 0 |
| sum_o | output | 1 | Serial result bit for the current slot |
| bit_strobe_o | output | WIDTH | One-hot bit-slot strobes |
| pc_adv_o | output | 1 | Program-counter advance pulse in the last slot |
| carry_o | output | 1 | Carry flag from the last packet |
| zero_o | output | 1 | Zero flag from the last packet |

## Verification
The bench builds the block at the default WIDTH of 8. At that width the byte-wrap corners can be reached directly: 0xFF+1, 0x00−1, equal-operand subtraction, and a carry that passes from one packet into the next ADC or SBB. It also allows about a thousand random packets that span all sixteen opcode codes, including the unused ones. In every packet the inputs are scrambled after slot 0, so each result also checks that later input changes are ignored.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_ADC = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_NOT = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_RSB = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG
  } cin_sel_e;

  typedef enum logic [1:0] {
    BSRC_OPND,
    BSRC_ZERO,
    BSRC_ONES
  } bsrc_e;

  typedef enum logic [2:0] {
    FN_SUM,
    FN_AND,
    FN_OR,
    FN_XOR,
    FN_PASS_A
  } fn_e;

  typedef struct packed {
    logic     inv_a;
    logic     inv_b;
    bsrc_e    bsrc;
    cin_sel_e cin;
    fn_e      fn;
  } ctrl_t;

  function automatic ctrl_t decode_op(logic [OP_W-1:0] op);
    ctrl_t c;
    c.inv_a = 1'b0;
    c.inv_b = 1'b0;
    c.bsrc  = BSRC_OPND;
    c.cin   = CIN_ZERO;
    c.fn    = FN_SUM;
    case (op)
      OP_SUB: begin c.inv_b = 1'b1; c.cin = CIN_ONE; end
      OP_ADC: c.cin = CIN_FLAG;
      OP_SBB: begin c.inv_b = 1'b1; c.cin = CIN_FLAG; end
      OP_AND: c.fn = FN_AND;
      OP_OR:  c.fn = FN_OR;
      OP_XOR: c.fn = FN_XOR;
      OP_NOT: begin c.inv_a = 1'b1; c.fn = FN_PASS_A; end
      OP_INC: begin c.bsrc = BSRC_ZERO; c.cin = CIN_ONE; end
      OP_DEC: c.bsrc = BSRC_ONES;
      OP_RSB: begin c.inv_a = 1'b1; c.cin = CIN_ONE; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/serial_alu_seq.sv
module serial_alu_seq #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] strobe_o,
  output logic             first_o,
  output logic             last_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_dec
    assign strobe_o[k] = (cnt_q == CW'(k));
  end

  assign first_o = strobe_o[0];
  assign last_o  = strobe_o[WIDTH-1];
endmodule

// File: rtl/serial_alu_shift.sv
module serial_alu_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             bit_o
);
  // bit 0 goes straight to the adder in slot 0; the rest is held here
  logic [WIDTH-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= par_i[WIDTH-1:1];
    else             sh_q <= sh_q >> 1;
  end

  assign bit_o = load_i ? par_i[0] : sh_q[0];
endmodule

// File: rtl/serial_alu_core.sv
module serial_alu_core
  import serial_alu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  first_i,
  input  ctrl_t ctrl_i,
  input  logic  a_bit_i,
  input  logic  b_bit_i,
  input  logic  flag_i,
  output logic  res_o,
  output logic  cout_o
);
  logic c_q;
  logic a, b, b_src, cin0, cin, g, p, res, cout;

  always_comb begin
    case (ctrl_i.bsrc)
      BSRC_ZERO: b_src = 1'b0;
      BSRC_ONES: b_src = 1'b1;
      default:   b_src = b_bit_i;
    endcase
    case (ctrl_i.cin)
      CIN_ONE:  cin0 = 1'b1;
      CIN_FLAG: cin0 = flag_i;
      default:  cin0 = 1'b0;
    endcase
    a    = a_bit_i ^ ctrl_i.inv_a;
    b    = b_src ^ ctrl_i.inv_b;
    cin  = first_i ? cin0 : c_q;
    g    = a & b;
    p    = a ^ b;
    cout = 1'b0;
    case (ctrl_i.fn)
      FN_AND:    res = g;
      FN_OR:     res = g | p;
      FN_XOR:    res = p;
      FN_PASS_A: res = a;
      default: begin
        res  = p ^ cin;
        cout = g | (p & cin);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) c_q <= 1'b0;
    else         c_q <= cout;
  end

  assign res_o  = res;
  assign cout_o = cout;
endmodule

// File: rtl/serial_alu_flags.sv
module serial_alu_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_i,
  input  logic last_i,
  input  logic res_i,
  input  logic cout_i,
  output logic carry_o,
  output logic zero_o
);
  logic z_run_q, carry_q, zero_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_run_q <= 1'b1;
      carry_q <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      if (first_i) z_run_q <= ~res_i;
      else         z_run_q <= z_run_q & ~res_i;
      if (last_i) begin
        carry_q <= cout_i;
        zero_q  <= z_run_q & ~res_i;
      end
    end
  end

  assign carry_o = carry_q;
  assign zero_o  = zero_q;
endmodule

// File: rtl/serial_alu.sv
module serial_alu
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [OP_W-1:0]  opcode_i,
  output logic             sum_o,
  output logic [WIDTH-1:0] bit_strobe_o,
  output logic             pc_adv_o,
  output logic             carry_o,
  output logic             zero_o
);
  logic            first, last, a_bit, b_bit, res, cout;
  logic [OP_W-1:0] op_q, op_cur;
  ctrl_t           ctrl;

  serial_alu_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i, .rst_ni, .strobe_o(bit_strobe_o), .first_o(first), .last_o(last)
  );

  serial_alu_shift #(.WIDTH(WIDTH)) u_sh_a (
    .clk_i, .rst_ni, .load_i(first), .par_i(opa_i), .bit_o(a_bit)
  );

  serial_alu_shift #(.WIDTH(WIDTH)) u_sh_b (
    .clk_i, .rst_ni, .load_i(first), .par_i(opb_i), .bit_o(b_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    op_q <= '0;
    else if (first) op_q <= opcode_i;
  end

  assign op_cur = first ? opcode_i : op_q;
  assign ctrl   = decode_op(op_cur);

  serial_alu_core u_core (
    .clk_i, .rst_ni, .first_i(first), .ctrl_i(ctrl), .a_bit_i(a_bit),
    .b_bit_i(b_bit), .flag_i(carry_o), .res_o(res), .cout_o(cout)
  );

  serial_alu_flags u_flags (
    .clk_i, .rst_ni, .first_i(first), .last_i(last), .res_i(res),
    .cout_i(cout), .carry_o, .zero_o
  );

  assign sum_o    = res;
  assign pc_adv_o = last;
endmodule

// File: rtl/serial_alu_chk.sv
module serial_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] bit_strobe_o,
  input logic             pc_adv_o,
  input logic             sum_o,
  input logic             carry_o,
  input logic             zero_o,
  input logic [3:0]       op_q
);
  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bit_strobe_o) == 1);

  a_r1_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> bit_strobe_o == {$past(bit_strobe_o[WIDTH-2:0]), $past(bit_strobe_o[WIDTH-1])});

  a_r2_pc_then_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_adv_o |=> bit_strobe_o[0]);

  a_r3_op_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_strobe_o[0] |=> $stable(op_q));

  a_r6_logic_clears_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_adv_o && op_q >= 4'd4 && op_q <= 4'd7) |=> !carry_o);

  a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_adv_o |=> ($stable(carry_o) && $stable(zero_o)));

  a_r9_one_bit_not_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_adv_o && sum_o) |=> !zero_o);
endmodule

bind serial_alu serial_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_strobe_o(bit_strobe_o),
  .pc_adv_o(pc_adv_o), .sum_o(sum_o), .carry_o(carry_o), .zero_o(zero_o),
  .op_q(op_q)
);

// File: tb/serial_alu_bench.sv
`timescale 1ns/1ps
module serial_alu_bench;
  localparam int W = 8;
  localparam int WD_CYCLES = 150000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [3:0]   opc = '0;
  logic         sum_o, pc_adv_o, carry_o, zero_o;
  logic [W-1:0] bit_strobe_o;

  int   n_run = 0, n_fail = 0;
  logic cf = 1'b0;
  logic pend = 1'b0, pend_c, pend_z;

  always #2 clk = ~clk;

  serial_alu #(.WIDTH(W)) u_serial_alu (
    .clk_i(clk), .rst_ni, .opa_i(opa), .opb_i(opb), .opcode_i(opc),
    .sum_o, .bit_strobe_o, .pc_adv_o, .carry_o, .zero_o
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd10:       return "R4 add/sub/rsb";
      4'd2, 4'd3:              return "R5 adc/sbb";
      4'd4, 4'd5, 4'd6, 4'd7:  return "R6 logic";
      4'd8, 4'd9:              return "R7 inc/dec";
      default:                 return "R10 unused code as add";
    endcase
  endfunction

  // {carry, result} from the requirement text
  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                       logic [3:0] op, logic c);
    logic [W:0] ea, eb;
    ea = {1'b0, a};
    eb = {1'b0, b};
    case (op)
      4'd1:  return ea + {1'b0, ~b} + 1;
      4'd2:  return ea + eb + (W+1)'(c);
      4'd3:  return ea + {1'b0, ~b} + (W+1)'(c);
      4'd4:  return {1'b0, a & b};
      4'd5:  return {1'b0, a | b};
      4'd6:  return {1'b0, a ^ b};
      4'd7:  return {1'b0, ~a};
      4'd8:  return ea + 1;
      4'd9:  return ea + {1'b0, {W{1'b1}}};
      4'd10: return {1'b0, ~a} + eb + 1;
      default: return ea + eb;
    endcase
  endfunction

  // entered at the negedge inside slot W-1; leaves at the negedge inside slot W-1
  task automatic run_pkt(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] op);
    logic [W:0]   e;
    logic [W-1:0] got;
    bit           seq_ok;
    logic [31:0]  bad_strobe;
    opa = a; opb = b; opc = op;
    e = model(a, b, op, cf);
    seq_ok = 1'b1;
    bad_strobe = '0;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      if (k == 0 && pend) begin
        check(carry_o == pend_c, "R8 carry flag", 32'(carry_o), 32'(pend_c));
        check(zero_o == pend_z, "R9 zero flag", 32'(zero_o), 32'(pend_z));
      end
      got[k] = sum_o;
      if (bit_strobe_o != (W'(1) << k) || pc_adv_o != (k == W-1)) begin
        seq_ok = 1'b0;
        bad_strobe = {23'b0, pc_adv_o, bit_strobe_o};
      end
      if (k == 1) begin
        opa = W'($urandom); opb = W'($urandom); opc = 4'($urandom);
      end
    end
    check(seq_ok, "R1/R2 strobe and pc_adv sequence", bad_strobe, 32'h0);
    check(got == e[W-1:0], {"R3 ", tag_of(op)}, 32'(got), 32'(e[W-1:0]));
    cf = e[W];
    pend_c = e[W];
    pend_z = (e[W-1:0] == '0);
    pend = 1'b1;
  endtask

  initial begin
    #(WD_CYCLES * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(bit_strobe_o == W'(1), "R1 reset strobe", 32'(bit_strobe_o), 32'h1);
    check(pc_adv_o == 1'b0, "R2 reset pc_adv", 32'(pc_adv_o), 32'h0);
    check(carry_o == 1'b0, "R1 reset carry", 32'(carry_o), 32'h0);
    check(zero_o == 1'b1, "R1 reset zero", 32'(zero_o), 32'h1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(bit_strobe_o == W'(2), "R1 first slot after reset", 32'(bit_strobe_o), 32'h2);
    while (!bit_strobe_o[W-1]) @(negedge clk);

    // directed corners
    run_pkt(8'hFF, 8'h01, 4'd0);  // R4 wrap, carry 1, zero 1
    run_pkt(8'h00, 8'h00, 4'd2);  // R5 adc uses carry 1 -> 1
    run_pkt(8'h05, 8'h05, 4'd1);  // R4 equal sub -> 0, carry 1
    run_pkt(8'h03, 8'h05, 4'd1);  // R4 borrow -> FE, carry 0
    run_pkt(8'h0A, 8'h03, 4'd3);  // R5 sbb with carry 0 -> 06
    run_pkt(8'h03, 8'h0A, 4'd10); // R4 reverse sub -> 07
    run_pkt(8'hFF, 8'h00, 4'd0);  // sets carry 0 before logic
    run_pkt(8'hFF, 8'hFF, 4'd0);  // carry 1
    run_pkt(8'hF0, 8'h3C, 4'd4);  // R6 and, carry cleared
    run_pkt(8'hF0, 8'h3C, 4'd5);  // R6 or
    run_pkt(8'hAA, 8'hAA, 4'd6);  // R6 xor -> 0
    run_pkt(8'h5A, 8'h00, 4'd7);  // R6 not -> A5
    run_pkt(8'hFF, 8'h77, 4'd8);  // R7 inc wrap
    run_pkt(8'h00, 8'h77, 4'd9);  // R7 dec wrap, carry 0
    run_pkt(8'h80, 8'h12, 4'd9);  // R7 dec, carry 1
    run_pkt(8'h40, 8'h41, 4'd12); // R10 unused code as add
    run_pkt(8'hFF, 8'h01, 4'd15); // R10 carry from unused code

    for (int i = 0; i < 1000; i++)
      run_pkt(W'($urandom), W'($urandom), 4'($urandom));

    @(negedge clk);
    check(carry_o == pend_c, "R8 final carry flag", 32'(carry_o), 32'(pend_c));
    check(zero_o == pend_z, "R9 final zero flag", 32'(zero_o), 32'(pend_z));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule